// File: doc/BRIEF.md
# Masked Interrupt Status Group with Vector Read

This block holds a set of interrupt sources on a simple processor bus. Each source owns a sticky status register and a mask register. Hardware pulses on a per-source set input latch status bits, and they stay latched until software clears them by writing ones to the status register. A source raises a registered interrupt flag when at least one of its status bits is set and not masked. The flags of all sources combine into one active-low interrupt request.

The bus is a plain asynchronous-style strobe interface: an address, write data, active-low read, write and request strobes, read data and a data-drive enable. For each source, the status register sits at an even offset and its mask at the next odd offset. A read that selects no register returns an 8-bit vector that identifies the pending source with the highest priority, so an acknowledge read can be taken from anywhere outside the register window. Source 0 has the highest priority.

Top module: `irqv_top`

## Requirements
- R1: After reset every status register reads 0, every interrupt flag is 0, `irq_n` is 1, and each mask register reads its reset default (source 0: 0x00, source 1: 0x0F by default).
- R2: A 1 on bit b of `src_set[i]` sets status bit b of source i at the next clock edge. The bit then stays set until software clears it.
- R3: A bus write to the status register of source i (offset 2·i) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends cleared.
- R5: The mask register of source i is at offset 2·i+1. It reads back what was last written, and a mask bit of 1 stops the matching status bit from raising the source's flag.
- R6: A source's flag is registered. It goes high one edge after its status holds an unmasked 1 and goes low one edge after no unmasked 1 remains.
- R7: `irq_n` is 0 exactly when at least one source flag is high.
- R8: When a read selects no register, `bus_rdata` shows the vector of the lowest-numbered source whose flag is high (0x10 for source 0, 0x20 for source 1 by default), or 0x00 if no flag is high.
- R9: When a read selects no register, `bus_oe` is 0.
- R10: A read with `bus_sel_n`=0 and `bus_rd_n`=0 at a register offset drives `bus_oe`=1 and returns that register's value in the same cycle.
- R11: Accesses with `bus_sel_n`=1, or with address bits above the offset field not equal to the base (0x0040 by default, offset field 2 bits wide), neither write nor read any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, or the vector when no register is selected |
| bus_oe | output | 1 | High while a register read is selected |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_sel_n | input | 1 | Active-low request strobe for this address space |
| src_set | input | NSRC×DW | Per-source hardware set bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A status bit is due one edge after its set pulse or clearing write. The source flag, `irq_n` and the vector are due one edge later still, because they come from the registered flag. Read data and `bus_oe` are combinational in the cycle of the read. The bench drives inputs on the falling edge and updates its model on the rising edge. It compares every output three nanoseconds after each falling edge, so each result is read in the cycle the model says it is due, including the extra flag cycle after a clear or mask change.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Slot type selected by the lowest offset bit of a register address.
  typedef enum logic {
    SLOT_STATUS = 1'b0,
    SLOT_MASK   = 1'b1
  } slot_e;

endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/irqv_decode.sv
module irqv_decode
  import irqv_pkg::*;
#(
  parameter int unsigned NSRC = 2,
  parameter int unsigned AW   = 16,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0040
) (
  input  logic [AW-1:0]   addr,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            sel_n,
  output logic [NSRC-1:0] sts_rd,
  output logic [NSRC-1:0] sts_wr,
  output logic [NSRC-1:0] msk_rd,
  output logic [NSRC-1:0] msk_wr
);

  localparam int unsigned LW = $clog2(2 * NSRC);
  localparam int unsigned IW = LW - 1;

  logic          blk_hit;
  logic          rd_act;
  logic          wr_act;
  slot_e         slot;
  logic [IW-1:0] idx;

  always_comb begin
    blk_hit = (addr[AW-1:LW] == BASE_ADDR[AW-1:LW]) && !sel_n;
    rd_act  = blk_hit && !rd_n;
    wr_act  = blk_hit && !wr_n;
    slot    = slot_e'(addr[0]);
    idx     = addr[LW-1:1];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    always_comb begin
      sts_rd[i] = rd_act && (slot == SLOT_STATUS) && (idx == IW'(i));
      sts_wr[i] = wr_act && (slot == SLOT_STATUS) && (idx == IW'(i));
      msk_rd[i] = rd_act && (slot == SLOT_MASK)   && (idx == IW'(i));
      msk_wr[i] = wr_act && (slot == SLOT_MASK)   && (idx == IW'(i));
    end
  end

endmodule

// File: rtl/irqv_source.sv
module irqv_source #(
  parameter int unsigned   DW       = 8,
  parameter logic [DW-1:0] MSK_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] wdata,
  input  logic          sts_wr,
  input  logic          msk_wr,
  output logic [DW-1:0] sts_q,
  output logic [DW-1:0] msk_q,
  output logic          flag_q
);

  logic [DW-1:0] clr_v;
  logic [DW-1:0] sts_d;
  logic [DW-1:0] msk_d;
  logic          flag_d;
  logic          msk_en;

  // Next state: clearing overrides a simultaneous set.
  always_comb begin
    clr_v  = {DW{sts_wr}} & wdata;
    sts_d  = (sts_q | set_i) & ~clr_v;
    msk_en = msk_wr;
    msk_d  = wdata;
    flag_d = |(sts_q & ~msk_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     msk_q <= MSK_INIT;
    else if (msk_en) msk_q <= msk_d;
  end

endmodule

// File: rtl/irqv_readmux.sv
module irqv_readmux #(
  parameter int unsigned NSRC = 2,
  parameter int unsigned DW   = 8,
  parameter logic [NSRC-1:0][DW-1:0] VEC_TABLE = {8'h20, 8'h10}
) (
  input  logic [NSRC-1:0]         flags,
  input  logic [NSRC-1:0]         sts_rd,
  input  logic [NSRC-1:0]         msk_rd,
  input  logic [NSRC-1:0][DW-1:0] sts_q,
  input  logic [NSRC-1:0][DW-1:0] msk_q,
  output logic [DW-1:0]           rdata,
  output logic                    oe
);

  logic [DW-1:0] vec;
  logic [DW-1:0] reg_data;

  // Walk from the highest index down so the lowest pending index wins.
  always_comb begin
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (flags[i]) vec = VEC_TABLE[i];
    end
  end

  // Selects are mutually exclusive, so an OR tree serves as the mux.
  always_comb begin
    reg_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      reg_data = reg_data | ({DW{sts_rd[i]}} & sts_q[i])
                          | ({DW{msk_rd[i]}} & msk_q[i]);
    end
  end

  always_comb begin
    oe    = |{sts_rd, msk_rd};
    rdata = oe ? reg_data : vec;
  end

endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int unsigned NSRC = 2,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 16,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0040,
  parameter logic [NSRC-1:0][DW-1:0] VEC_TABLE = {8'h20, 8'h10},
  parameter logic [NSRC-1:0][DW-1:0] MSK_INIT  = {8'h0F, 8'h00}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic                    bus_oe,
  input  logic                    bus_rd_n,
  input  logic                    bus_wr_n,
  input  logic                    bus_sel_n,
  input  logic [NSRC-1:0][DW-1:0] src_set,
  output logic                    irq_n
);

  logic                    rst_q_n;
  logic [NSRC-1:0]         sts_rd;
  logic [NSRC-1:0]         sts_wr;
  logic [NSRC-1:0]         msk_rd;
  logic [NSRC-1:0]         msk_wr;
  logic [NSRC-1:0][DW-1:0] sts_q;
  logic [NSRC-1:0][DW-1:0] msk_q;
  logic [NSRC-1:0]         flag_q;

  irqv_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_ni  (rst_n),
    .rst_q_n (rst_q_n)
  );

  irqv_decode #(.NSRC(NSRC), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr   (bus_addr),
    .rd_n   (bus_rd_n),
    .wr_n   (bus_wr_n),
    .sel_n  (bus_sel_n),
    .sts_rd (sts_rd),
    .sts_wr (sts_wr),
    .msk_rd (msk_rd),
    .msk_wr (msk_wr)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irqv_source #(.DW(DW), .MSK_INIT(MSK_INIT[i])) u_src (
      .clk    (clk),
      .rst_ni (rst_q_n),
      .set_i  (src_set[i]),
      .wdata  (bus_wdata),
      .sts_wr (sts_wr[i]),
      .msk_wr (msk_wr[i]),
      .sts_q  (sts_q[i]),
      .msk_q  (msk_q[i]),
      .flag_q (flag_q[i])
    );
  end

  irqv_readmux #(.NSRC(NSRC), .DW(DW), .VEC_TABLE(VEC_TABLE)) u_mux (
    .flags  (flag_q),
    .sts_rd (sts_rd),
    .msk_rd (msk_rd),
    .sts_q  (sts_q),
    .msk_q  (msk_q),
    .rdata  (bus_rdata),
    .oe     (bus_oe)
  );

  assign irq_n = ~(|flag_q);

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int unsigned NSRC = 2,
  parameter int unsigned DW   = 8,
  parameter logic [NSRC-1:0][DW-1:0] VEC_TABLE = {8'h20, 8'h10}
) (
  input logic                    clk,
  input logic                    rst_q_n,
  input logic [NSRC-1:0][DW-1:0] sts_q,
  input logic [NSRC-1:0][DW-1:0] msk_q,
  input logic [NSRC-1:0]         flag_q,
  input logic [NSRC-1:0]         sts_wr,
  input logic [NSRC-1:0][DW-1:0] src_set,
  input logic [DW-1:0]           bus_wdata,
  input logic [DW-1:0]           bus_rdata,
  input logic                    bus_oe,
  input logic                    bus_rd_n,
  input logic                    bus_sel_n,
  input logic                    irq_n
);

  logic [NSRC-1:0][DW-1:0] land_v;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      land_v[i] = src_set[i] & ~(sts_wr[i] ? bus_wdata : '0);
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_q_n)
      (land_v[i] != '0) |=> ((sts_q[i] & $past(land_v[i])) == $past(land_v[i]))); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_q_n)
      sts_wr[i] |=> ((sts_q[i] & $past(bus_wdata)) == '0)); // R4

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
      $rose(flag_q[i]) |-> $past((sts_q[i] & ~msk_q[i]) != '0)); // R6
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_q != '0) == !irq_n); // R7

  AST_OE_QUAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_oe |-> (!bus_rd_n && !bus_sel_n)); // R10

  AST_VEC_FIRST: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_q[0] && !bus_oe) |-> (bus_rdata == VEC_TABLE[0])); // R8

endmodule

bind irqv_top irqv_chk #(.NSRC(NSRC), .DW(DW), .VEC_TABLE(VEC_TABLE)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .sts_q     (sts_q),
  .msk_q     (msk_q),
  .flag_q    (flag_q),
  .sts_wr    (sts_wr),
  .src_set   (src_set),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_oe    (bus_oe),
  .bus_rd_n  (bus_rd_n),
  .bus_sel_n (bus_sel_n),
  .irq_n     (irq_n)
);

// File: tb/sim_irqv_top.sv
module sim_irqv_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0040;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     bus_addr = 16'h0000;
  logic [7:0]      bus_wdata = 8'h00;
  logic [7:0]      bus_rdata;
  logic            bus_oe;
  logic            bus_rd_n = 1'b1;
  logic            bus_wr_n = 1'b1;
  logic            bus_sel_n = 1'b1;
  logic [1:0][7:0] src_set = '0;
  logic            irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqv_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_oe    (bus_oe),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_sel_n (bus_sel_n),
    .src_set   (src_set),
    .irq_n     (irq_n)
  );

  // Behavioural reference state
  logic [7:0] m_sts [2];
  logic [7:0] m_msk [2];
  bit         m_flag [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_block();
    return !bus_sel_n && ((bus_addr >> 2) == (BASE >> 2));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts[0] <= 8'h00; m_sts[1] <= 8'h00;
      m_msk[0] <= 8'h00; m_msk[1] <= 8'h0F;
      m_flag[0] <= 0;    m_flag[1] <= 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [7:0] clr;
        int off;
        off = int'(bus_addr[1:0]);
        clr = (in_block() && !bus_wr_n && off == 2*i) ? bus_wdata : 8'h00;
        m_flag[i] <= (m_sts[i] & ~m_msk[i]) != 8'h00;
        m_sts[i]  <= (m_sts[i] | src_set[i]) & ~clr;
        if (in_block() && !bus_wr_n && off == 2*i+1) m_msk[i] <= bus_wdata;
      end
    end
  end

  // Compare every cycle, 3 time units after the falling edge.
  always begin
    @(negedge clk);
    #3;
    if (!done) begin
      bit e_oe;
      logic [7:0] e_rd;
      int off;
      off  = int'(bus_addr[1:0]);
      e_oe = in_block() && !bus_rd_n;
      if (e_oe) e_rd = off[0] ? m_msk[off/2] : m_sts[off/2];
      else      e_rd = m_flag[0] ? 8'h10 : (m_flag[1] ? 8'h20 : 8'h00);
      chk("R7 irq_n", irq_n, !(m_flag[0] || m_flag[1]));
      chk(e_oe ? "R10 bus_oe" : "R9 bus_oe", bus_oe, e_oe);
      chk(e_oe ? (off[0] ? "R5 rdata" : "R10 rdata") : "R8 rdata", bus_rdata, e_rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_n = 1'b0; bus_sel_n = !sel;
    @(negedge clk);
    bus_wr_n = 1'b1; bus_sel_n = 1'b1;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic oe,
                          input bit sel = 1);
    @(negedge clk);
    bus_addr = a; bus_rd_n = 1'b0; bus_sel_n = !sel;
    #3;
    d = bus_rdata; oe = bus_oe;
    @(negedge clk);
    bus_rd_n = 1'b1; bus_sel_n = 1'b1;
  endtask

  task automatic pulse_set(input int i, input logic [7:0] v);
    @(negedge clk);
    src_set[i] = v;
    @(negedge clk);
    src_set[i] = 8'h00;
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_read(BASE + 0, d, oe); chk("R1 sts0", d, 8'h00);
    bus_read(BASE + 2, d, oe); chk("R1 sts1", d, 8'h00);
    bus_read(BASE + 1, d, oe); chk("R1 msk0", d, 8'h00);
    bus_read(BASE + 3, d, oe); chk("R1 msk1", d, 8'h0F);
    chk("R1 irq_n", irq_n, 1'b1);

    // R2 sticky set, R6/R7 flag and irq, R8/R9 vector on outside read
    pulse_set(0, 8'h05);
    idle(3);
    bus_read(BASE + 0, d, oe); chk("R2 sts0", d, 8'h05); chk("R10 oe", oe, 1'b1);
    chk("R7 irq low", irq_n, 1'b0);
    bus_read(16'h0100, d, oe); chk("R8 vec0", d, 8'h10); chk("R9 oe", oe, 1'b0);

    // R3 write-one-to-clear
    bus_write(BASE + 0, 8'h01);
    bus_read(BASE + 0, d, oe); chk("R3 partial", d, 8'h04);
    bus_write(BASE + 0, 8'h00);
    bus_read(BASE + 0, d, oe); chk("R3 zero write", d, 8'h04);
    bus_write(BASE + 0, 8'h04);
    idle(2);
    chk("R6 flag dropped", irq_n, 1'b1);
    bus_read(16'h0100, d, oe); chk("R8 none", d, 8'h00);

    // R4 clear wins over simultaneous set
    @(negedge clk);
    src_set[0] = 8'h02;
    bus_addr = BASE + 0; bus_wdata = 8'h02; bus_wr_n = 1'b0; bus_sel_n = 1'b0;
    @(negedge clk);
    src_set[0] = 8'h00; bus_wr_n = 1'b1; bus_sel_n = 1'b1;
    bus_read(BASE + 0, d, oe); chk("R4 clear wins", d, 8'h00);

    // R5 mask suppresses
    bus_write(BASE + 1, 8'hFF);
    bus_read(BASE + 1, d, oe); chk("R5 mask rb", d, 8'hFF);
    pulse_set(0, 8'h80);
    idle(3);
    chk("R5 masked irq", irq_n, 1'b1);
    bus_write(BASE + 1, 8'h00);
    idle(2);
    chk("R5 unmasked irq", irq_n, 1'b0);

    // Source 1 default mask hides low nibble
    bus_write(BASE + 0, 8'h80);
    pulse_set(1, 8'h01);
    idle(3);
    chk("R5 default mask", irq_n, 1'b1);
    pulse_set(1, 8'h10);
    idle(3);
    bus_read(16'h0100, d, oe); chk("R8 vec1", d, 8'h20);

    // R8 priority: both pending -> source 0
    pulse_set(0, 8'h40);
    idle(3);
    bus_read(16'h0100, d, oe); chk("R8 priority", d, 8'h10);
    bus_write(BASE + 0, 8'h40);
    idle(2);
    bus_read(16'h0100, d, oe); chk("R8 back to 1", d, 8'h20);

    // R11 no effect outside block
    bus_write(BASE + 2, 8'hFF, 0);
    bus_write(16'h0140 + 2, 8'hFF);
    bus_write(16'h0141, 8'hAA);
    bus_read(BASE + 2, d, oe); chk("R11 sts1 kept", d, 8'h11);
    bus_read(BASE + 1, d, oe); chk("R11 msk0 kept", d, 8'h00);
    bus_read(BASE + 2, d, oe, 0); chk("R11 no oe", oe, 1'b0);
    chk("R11 vec shown", d, 8'h20);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule